// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Sequencer

This block sits on the host side of a parallel ATA cable and runs one programmed-I/O access at a time: a register read or write, or one word on the data port. A request carries the direction, the register block (command or control), a 3-bit register address, the write word and the PIO mode. The sequencer then drives the address and chip selects, pulses the read or write strobe, drives the data bus during writes and watches IORDY for flow control. It returns the read word, or a completion for a write, on a response channel.

All bus timings come from per-mode nanosecond minimums. Each minimum becomes a clock count by ceiling division by the clock period parameter `CLK_NS` when the design is elaborated. The recovery phase after the strobe is stretched until the whole access meets the mode's minimum cycle time. IORDY passes through a `SYNC_STAGES`-flop synchronizer. The strobe is only released once the synchronized IORDY is high and the IORDY sampling delay has elapsed. If IORDY stays low past the flow-control limit, the access ends anyway and is flagged as timed out.

Both the request and the response are valid/ready channels. A request is taken only when the sequencer is idle and its previous response has left or is leaving in the same cycle. A response stays valid, with its content frozen, until it is accepted. While a response waits, no new bus access starts.

Top module: `ata_pio_host`

## Requirements
- R1: After reset and between accesses, req_ready is 1, rsp_valid is 0, both strobes are high, ata_cs_n is 2'b11 and ata_dd_oe is 0. During an access req_ready is 0. A request is accepted on a clock edge where req_valid and req_ready are both 1.
- R2: Address and chip select are driven from the first cycle after acceptance. The strobe falls exactly T1 = ceil(t1/CLK_NS) cycles later, with t1 = 70, 50, 30, 30, 25 ns for modes 0..4. Address and chip select stay stable while the strobe is low.
- R3: With IORDY high, the strobe stays low for exactly T2 = ceil(t2/CLK_NS) cycles, with t2 = 165, 125, 100, 80, 70 ns.
- R4: req_ctrl=0 drives ata_cs_n=2'b10 and req_ctrl=1 drives ata_cs_n=2'b01. A read pulses only ata_dior_n and a write pulses only ata_diow_n. Both strobes are never low together.
- R5: After the strobe rises, address and chip select stay driven for exactly H cycles and are then released (ata_cs_n=2'b11). For a read, H = ceil(t9/CLK_NS) with t9 = 20, 15, 10, 10, 10 ns. For a write, H is the larger of that and ceil(t4/CLK_NS) with t4 = 30, 20, 15, 10, 10 ns.
- R6: rsp_valid rises L cycles after acceptance. L = max(T0, T1 + W + max(H, T2I)), where W is the strobe width and T0, T2I are the cycle counts of t0 = 600, 383, 240, 180, 120 ns and recovery t2i = 0, 0, 0, 70, 25 ns.
- R7: If IORDY is low when sampled, the strobe stays low until the synchronized IORDY is high. If IORDY rises during strobe cycle h (counting from 0), W = max(T2, h + 1 + SYNC_STAGES).
- R8: If synchronized IORDY stays low, the strobe rises after TA + TMO cycles, with TA = ceil(35/CLK_NS) and TMO = ceil(1250/CLK_NS). The response then carries rsp_timeout=1. Otherwise rsp_timeout=0.
- R9: For a read, rsp_rdata is the ata_dd_in value sampled on the edge that raises ata_dior_n. For a write, rsp_rdata is 0. ata_dd_oe is 1 and ata_dd_out equals req_wdata from the first setup cycle to the last hold cycle of a write, and 0 for a read.
- R10: A req_mode value above 4 is timed as mode 4.
- R11: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_rdata and rsp_timeout hold, req_ready is 0 and no bus access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_NS |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_ctrl | input | 1 | 1 = control block select, 0 = command block |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write word |
| req_mode | input | 3 | PIO mode, values above 4 act as 4 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Read word, 0 for writes |
| rsp_timeout | output | 1 | IORDY flow-control limit exceeded |
| ata_da | output | ADDR_W | Bus register address |
| ata_cs_n | output | 2 | Bus chip selects, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DATA_W | Bus data driven by host |
| ata_dd_oe | output | 1 | Bus data output enable |
| ata_dd_in | input | DATA_W | Bus data from device |
| ata_iordy | input | 1 | Device ready, asynchronous |

## Verification
Count cycles from the acceptance edge. Chip select appears in cycle 0, and the strobe falls at cycle T1 and lasts W cycles. Address release follows H cycles after that, and rsp_valid is first seen in cycle L. The bench samples every output at the falling clock edge, records the index at which each transition appears, and compares it with L, W and H computed from the nanosecond tables.

The device model changes ata_dd_in on every strobe cycle, so a read capture one cycle early or late shows up as a different word. IORDY is raised at a chosen strobe cycle, so W follows from the synchronizer depth.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int CNT_W = 12;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t setup;    // address valid to strobe fall
    cnt_t active;   // strobe low width
    cnt_t recov;    // strobe high minimum
    cnt_t cycle;    // whole access minimum
    cnt_t hold_wr;  // bus hold after write strobe
    cnt_t hold_rd;  // bus hold after read strobe
  } pio_timing_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_NEG
  } seq_state_t;

  function automatic cnt_t ns_to_clk(input int ns, input int clk_ns);
    return cnt_t'((ns + clk_ns - 1) / clk_ns);
  endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS = 10
) (
  input  logic [2:0]  mode,
  output pio_timing_t tim
);

  int ns_cyc, ns_set, ns_act, ns_rec, ns_wh, ns_ah;

  always_comb begin
    case (mode)
      3'd0: begin ns_cyc = 600; ns_set = 70; ns_act = 165; ns_rec = 0;  ns_wh = 30; ns_ah = 20; end
      3'd1: begin ns_cyc = 383; ns_set = 50; ns_act = 125; ns_rec = 0;  ns_wh = 20; ns_ah = 15; end
      3'd2: begin ns_cyc = 240; ns_set = 30; ns_act = 100; ns_rec = 0;  ns_wh = 15; ns_ah = 10; end
      3'd3: begin ns_cyc = 180; ns_set = 30; ns_act = 80;  ns_rec = 70; ns_wh = 10; ns_ah = 10; end
      default: begin ns_cyc = 120; ns_set = 25; ns_act = 70; ns_rec = 25; ns_wh = 10; ns_ah = 10; end
    endcase
    tim.cycle   = ns_to_clk(ns_cyc, CLK_NS);
    tim.setup   = ns_to_clk(ns_set, CLK_NS);
    tim.active  = ns_to_clk(ns_act, CLK_NS);
    tim.recov   = ns_to_clk(ns_rec, CLK_NS);
    tim.hold_rd = ns_to_clk(ns_ah, CLK_NS);
    tim.hold_wr = ns_to_clk((ns_wh > ns_ah) ? ns_wh : ns_ah, CLK_NS);
  end

endmodule

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} & {STAGES{1'b1}};
      end
      assign dout = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ctrl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [2:0]        req_mode,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic [ADDR_W-1:0] ata_da,
  output logic [1:0]        ata_cs_n,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DATA_W-1:0] ata_dd_in,
  input  logic              ata_iordy
);

  localparam cnt_t TA_C    = ns_to_clk(35, CLK_NS);
  localparam cnt_t TMO_C   = ns_to_clk(1250, CLK_NS);
  localparam cnt_t STR_MAX = TA_C + TMO_C;

  seq_state_t        state_q;
  cnt_t              cnt_q, tot_q, cnt_nx, tot_nx, hold_c;
  logic              wr_q, ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [2:0]        mode_q;
  logic              rsp_valid_q, rsp_tmo_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              iordy_s, ready_ok, tmo_hit, neg_done, bus_hold;
  pio_timing_t       tim;

  ata_pio_timing #(.CLK_NS(CLK_NS)) u_timing (
    .mode (mode_q),
    .tim  (tim)
  );

  ata_pio_sync #(.STAGES(SYNC_STAGES)) u_iordy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ata_iordy),
    .dout  (iordy_s)
  );

  always_comb begin
    cnt_nx   = cnt_q + cnt_t'(1);
    tot_nx   = tot_q + cnt_t'(1);
    hold_c   = wr_q ? tim.hold_wr : tim.hold_rd;
    ready_ok = iordy_s && (cnt_nx >= tim.active) && (cnt_nx >= TA_C);
    tmo_hit  = cnt_nx >= STR_MAX;
    neg_done = (cnt_nx >= hold_c) && (cnt_nx >= tim.recov) && (tot_nx >= tim.cycle);
    bus_hold = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
               ((state_q == ST_NEG) && (cnt_q < hold_c));
  end

  assign req_ready   = (state_q == ST_IDLE) && (!rsp_valid_q || rsp_ready);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign rsp_timeout = rsp_tmo_q;

  assign ata_da     = bus_hold ? addr_q : '0;
  assign ata_cs_n   = bus_hold ? (ctrl_q ? 2'b01 : 2'b10) : 2'b11;
  assign ata_dior_n = !((state_q == ST_STROBE) && !wr_q);
  assign ata_diow_n = !((state_q == ST_STROBE) && wr_q);
  assign ata_dd_oe  = bus_hold && wr_q;
  assign ata_dd_out = ata_dd_oe ? wdata_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      tot_q       <= '0;
      wr_q        <= 1'b0;
      ctrl_q      <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      mode_q      <= 3'd0;
      rsp_valid_q <= 1'b0;
      rsp_tmo_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            wr_q    <= req_write;
            ctrl_q  <= req_ctrl;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mode_q  <= req_mode;
            cnt_q   <= '0;
            tot_q   <= '0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          tot_q <= tot_nx;
          if (cnt_nx >= tim.setup) begin
            cnt_q   <= '0;
            state_q <= ST_STROBE;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
        ST_STROBE: begin
          tot_q <= tot_nx;
          if (ready_ok || tmo_hit) begin
            rsp_rdata_q <= wr_q ? '0 : ata_dd_in;
            rsp_tmo_q   <= !ready_ok;
            cnt_q       <= '0;
            state_q     <= ST_NEG;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
        default: begin
          tot_q <= tot_nx;
          if (neg_done) begin
            rsp_valid_q <= 1'b1;
            cnt_q       <= '0;
            state_q     <= ST_IDLE;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic strobe_any, cs_any;
  cnt_t str_age_q, cs_age_q;
  assign strobe_any = !ata_dior_n || !ata_diow_n;
  assign cs_any     = ata_cs_n != 2'b11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_age_q <= '0;
      cs_age_q  <= '0;
    end else begin
      str_age_q <= strobe_any ? str_age_q + cnt_t'(1) : '0;
      cs_age_q  <= (cs_any && !strobe_any) ? cs_age_q + cnt_t'(1) : '0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n)); // R4
  AST_STROBE_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> ($countones(~ata_cs_n) == 1)); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && $past(strobe_any)) |-> ($stable(ata_da) && $stable(ata_cs_n))); // R2
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_any) |-> (cs_age_q >= tim.setup)); // R2
  AST_WIDTH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_any) |-> (str_age_q >= tim.active)); // R3
  AST_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> (str_age_q < STR_MAX)); // R8
  AST_OE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> (cs_any && ata_dior_n)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_timeout))); // R11
  AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R11

endmodule

// File: tb/tb_ata_pio_host.sv
module tb_ata_pio_host;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ctrl = 1'b0;
  logic [2:0]  req_addr = '0, req_mode = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic [2:0]  ata_da;
  logic [1:0]  ata_cs_n;
  logic        ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = '0;
  logic        ata_iordy = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_host #(.CLK_NS(CLK_PERIOD), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_ctrl(req_ctrl), .req_addr(req_addr), .req_wdata(req_wdata), .req_mode(req_mode),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .ata_da(ata_da), .ata_cs_n(ata_cs_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );

  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // hold_h: -1 IORDY stays high, -2 IORDY never rises, >=0 rises in strobe cycle hold_h
  task automatic run_access(input bit wr, input bit ctrl, input logic [2:0] addr,
                            input logic [15:0] wd, input logic [2:0] mode,
                            input int hold_h, input bit stall, input string tag);
    int m, t0, t1, t2, t2i, t4, t9, ta, tmo, T1, T2, T0, T2I, TH, W, L;
    int cs_first, cs_last, str_first, nstr, rsp_idx, oe_cnt, bad_cs, bad_str, bad_da, busy_rdy;
    logic [15:0] pat, got_rd;
    logic got_tmo;
    m = (mode > 3'd4) ? 4 : int'(mode);   // R10
    case (m)
      0: begin t0 = 600; t1 = 70; t2 = 165; t2i = 0;  t4 = 30; t9 = 20; end
      1: begin t0 = 383; t1 = 50; t2 = 125; t2i = 0;  t4 = 20; t9 = 15; end
      2: begin t0 = 240; t1 = 30; t2 = 100; t2i = 0;  t4 = 15; t9 = 10; end
      3: begin t0 = 180; t1 = 30; t2 = 80;  t2i = 70; t4 = 10; t9 = 10; end
      default: begin t0 = 120; t1 = 25; t2 = 70; t2i = 25; t4 = 10; t9 = 10; end
    endcase
    ta = cyc(35); tmo = cyc(1250);
    T0 = cyc(t0); T1 = cyc(t1); T2 = cyc(t2); T2I = cyc(t2i);
    TH = wr ? mx(cyc(t4), cyc(t9)) : cyc(t9);
    if (hold_h == -1)      W = T2;
    else if (hold_h == -2) W = ta + tmo;
    else                   W = mx(T2, hold_h + 1 + SYNC);
    L = mx(T0, T1 + W + mx(TH, T2I));
    pat = 16'h5A00 ^ {13'd0, addr} ^ {m[7:0], 8'h00};

    rsp_ready = !stall;
    @(negedge clk);
    chk({"R1 ", tag, " ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_ctrl = ctrl; req_addr = addr;
    req_wdata = wd; req_mode = mode;
    if (hold_h != -1) ata_iordy = 1'b0;
    cs_first = -1; cs_last = -1; str_first = -1; nstr = 0; rsp_idx = -1;
    oe_cnt = 0; bad_cs = 0; bad_str = 0; bad_da = 0; busy_rdy = 0;
    got_rd = '0; got_tmo = 1'b0;
    for (int i = 0; i < L + 4; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (ata_cs_n != 2'b11) begin
        if (cs_first < 0) cs_first = i;
        cs_last = i;
        if (ata_cs_n != (ctrl ? 2'b01 : 2'b10)) bad_cs++;
        if (ata_da != addr) bad_da++;
      end
      if (ata_dd_oe) begin
        oe_cnt++;
        if (ata_dd_out != wd) bad_da++;
      end
      if (!ata_dior_n || !ata_diow_n) begin
        if (str_first < 0) str_first = i;
        if ((wr && !ata_dior_n) || (!wr && !ata_diow_n)) bad_str++;
        ata_dd_in = pat ^ 16'(nstr);
        if (hold_h >= 0 && nstr == hold_h) ata_iordy = 1'b1;
        nstr++;
      end
      if (rsp_valid) begin
        rsp_idx = i; got_rd = rsp_rdata; got_tmo = rsp_timeout;
        break;
      end
      if (req_ready) busy_rdy++;
    end
    ata_iordy = 1'b1;
    chk({"R6 ", tag, " response cycle"}, rsp_idx, L);
    chk({"R2 ", tag, " strobe fall cycle"}, str_first, T1);
    if (hold_h == -1)      chk({"R3 ", tag, " strobe width"}, nstr, W);
    else if (hold_h == -2) chk({"R8 ", tag, " strobe width at limit"}, nstr, W);
    else                   chk({"R7 ", tag, " strobe width with IORDY"}, nstr, W);
    chk({"R5 ", tag, " select first"}, cs_first, 0);
    chk({"R5 ", tag, " select last"}, cs_last, T1 + W + TH - 1);
    chk({"R4 ", tag, " select code and strobe kind"}, bad_cs + bad_str, 0);
    chk({"R2 ", tag, " address and data values"}, bad_da, 0);
    chk({"R9 ", tag, " output enable cycles"}, oe_cnt, wr ? (T1 + W + TH) : 0);
    chk({"R9 ", tag, " returned word"}, int'(got_rd), wr ? 0 : int'(pat ^ 16'(W - 1)));
    chk({"R8 ", tag, " timeout flag"}, int'(got_tmo), (hold_h == -2) ? 1 : 0);
    chk({"R1 ", tag, " ready low while busy"}, busy_rdy, 0);
    if (stall) begin
      req_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk({"R11 ", tag, " response held"}, int'(rsp_valid), 1);
        chk({"R11 ", tag, " word held"}, int'(rsp_rdata), int'(got_rd));
        chk({"R11 ", tag, " no request taken"}, int'(req_ready), 0);
        chk({"R11 ", tag, " bus idle"}, int'(ata_cs_n), 3);
      end
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      chk({"R11 ", tag, " response released"}, int'(rsp_valid), 0);
    end
    @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);
    chk("R1 reset cs_n", int'(ata_cs_n), 3);
    chk("R1 reset strobes", int'({ata_dior_n, ata_diow_n}), 3);
    chk("R1 reset oe", int'(ata_dd_oe), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    test_reset();
    run_access(1'b0, 1'b0, 3'd7, 16'h0000, 3'd0, -1, 1'b0, "rd m0");
    run_access(1'b1, 1'b1, 3'd6, 16'hC3A5, 3'd4, -1, 1'b0, "wr m4 ctrl");
    run_access(1'b0, 1'b1, 3'd3, 16'h0000, 3'd2, -1, 1'b0, "rd m2 ctrl");
    run_access(1'b1, 1'b0, 3'd1, 16'h1234, 3'd3, 20, 1'b0, "wr m3 iordy");
    run_access(1'b0, 1'b0, 3'd2, 16'h0000, 3'd1, -2, 1'b0, "rd m1 stuck");
    run_access(1'b0, 1'b0, 3'd5, 16'h0000, 3'd7, -1, 1'b0, "R10 rd m7");
    run_access(1'b1, 1'b0, 3'd0, 16'hFFFF, 3'd6, -1, 1'b0, "R10 wr m6");
    run_access(1'b0, 1'b0, 3'd4, 16'h0000, 3'd4, 2, 1'b0, "rd m4 short iordy");
    run_access(1'b0, 1'b1, 3'd6, 16'h0000, 3'd3, -1, 1'b1, "rd m3 stall");
    run_access(1'b1, 1'b0, 3'd2, 16'h8001, 3'd1, 30, 1'b0, "wr m1 iordy");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule